// File: doc/BRIEF.md
# Dual-Role Serial Host Register Port

This block is the host-side register file of an audio decoder. A host controller reaches it through a four-wire clocked serial slave port: serial clock, data in, data out with its own output enable, and an active-low select. The pins are oversampled by the block's system clock, so the serial clock must run well below it.

Behind the port sit three groups of registers. Read-only registers mirror bitstream, burst, status and write-pointer values from the decoder core. Read/write control bytes drive the core. A 16-bit read pointer accepts writes only while the core is not decoding.

A role input moves the decoded address window by 0x40. Two identical devices can then share one serial bus, one answering as main and one as sub. Each transfer is one command byte followed by one or more data bytes. The address advances after every data byte.

Top module: `hrp_host_port`

## Requirements
- R1: A transfer starts when `ss_ni` falls and ends when it rises. Data in is sampled MSB first on rising serial clock edges. The first byte is a command: bit 7 = 1 means read, 0 means write, and bits 6..0 hold the address.
- R2: Read data is shifted out MSB first and changes only after falling serial clock edges. The first data bit appears after the falling edge that follows the command byte. `sdo_oe_o` is high only while an in-window address is being read, and it drops once select is high.
- R3: With `sub_role_i`=0 (main) the device answers addresses 0x00..0x3F. With `sub_role_i`=1 (sub) it answers 0x40..0x7F, and every register sits at its main address plus 0x40.
- R4: Writes to addresses outside the device's window are ignored. Reads outside the window keep `sdo_oe_o` low.
- R5: The following locations are read-only, and writes to them are ignored:
  - local offsets 0x00..0x0D return byte n of `bs_info_i` (bits 8n+7..8n);
  - 0x0E returns the status byte;
  - 0x0F returns the CRC status byte;
  - 0x12 and 0x13 return `wr_ptr_i`, high byte at 0x12.
- R6: After reset the status byte reads 0x03 (bit 0 = not locked, bit 1 = sync word not found), the CRC status byte reads 0x00, the read pointer is 0 and all control bytes are 0.
- R7: The read pointer sits at 0x10 (high byte) and 0x11 (low byte). Host writes change it only while `decoding_i` is low; while `decoding_i` is high they are ignored. `rd_ptr_o` shows its value.
- R8: While select stays low, the address increments by one after each data byte, for reads and writes alike.
- R9: NUM_CTRL control bytes at local offsets 0x14 upward are readable and writable. Control byte k appears on `ctrl_o` bits 8k+7..8k.
- R10: A one-cycle pulse on `stat_we_i` loads `stat_i` into the status byte and `crc_i` into the CRC status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| ss_ni | input | 1 | Select, active low |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| sub_role_i | input | 1 | 0 main window, 1 sub window |
| decoding_i | input | 1 | Core is decoding |
| bs_info_i | input | NUM_BS*8 | Bitstream and burst info bytes |
| stat_we_i | input | 1 | Status load strobe |
| stat_i | input | 8 | New status byte |
| crc_i | input | 8 | New CRC status byte |
| wr_ptr_i | input | 16 | Core write pointer |
| rd_ptr_o | output | 16 | Read pointer |
| ctrl_o | output | NUM_CTRL*8 | Control bytes |

## Verification
A wrong command bit count or a wrong window decode shows up on the very first read: `sdo_oe_o` either stays low or rises for the wrong device within one serial bit time. A faulty increment or a faulty write qualifier corrupts a later byte. That later byte is therefore read back over the port, and `rd_ptr_o` and `ctrl_o` are compared directly. A missed write-permission check during decoding changes `rd_ptr_o` a few system cycles after the last rising serial edge of the data byte.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam logic [5:0] OFF_STAT  = 6'h0E;
  localparam logic [5:0] OFF_CRC   = 6'h0F;
  localparam logic [5:0] OFF_RDP_H = 6'h10;
  localparam logic [5:0] OFF_RDP_L = 6'h11;
  localparam logic [5:0] OFF_WRP_H = 6'h12;
  localparam logic [5:0] OFF_WRP_L = 6'h13;
  localparam logic [5:0] OFF_CTRL  = 6'h14;
  localparam logic [7:0] STAT_RST  = 8'h03;

  typedef struct packed {
    logic [6:0] addr;
    logic [7:0] data;
  } hrp_wr_t;
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st <= {2{RST_VAL[i]}};
      else         st <= {st[0], d_i[i]};
    end
    assign q_o[i] = st[1];
  end
endmodule

// File: rtl/hrp_serial_if.sv
module hrp_serial_if
  import hrp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       sdi_i,
  input  logic       ss_ni,
  input  logic [7:0] rdata_i,
  input  logic       rhit_i,
  output logic [6:0] look_addr_o,
  output logic       wr_stb_o,
  output hrp_wr_t    wr_o,
  output logic       sdo_o,
  output logic       sdo_oe_o
);
  logic [2:0] s;
  logic sck_s, sdi_s, ss_s, sck_q;
  hrp_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({sck_i, sdi_i, ss_ni}), .q_o(s)
  );
  assign {sck_s, sdi_s, ss_s} = s;

  logic       cmd_ph, rd_mode, tx_hit;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr, addr_q;
  logic [7:0] tx_sr, byte_full;
  logic       rise, fall, active;

  assign active    = !ss_s;
  assign rise      = active && sck_s && !sck_q;
  assign fall      = active && !sck_s && sck_q;
  assign byte_full = {rx_sr, sdi_s};
  // next address to be read: command target, or the incremented one
  assign look_addr_o = cmd_ph ? byte_full[6:0] : addr_q + 7'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0; cmd_ph <= 1'b1; rd_mode <= 1'b0; tx_hit <= 1'b0;
      bit_cnt <= '0; rx_sr <= '0; addr_q <= '0; tx_sr <= '0;
      sdo_o <= 1'b0; sdo_oe_o <= 1'b0; wr_stb_o <= 1'b0; wr_o <= '0;
    end else begin
      sck_q    <= sck_s;
      wr_stb_o <= 1'b0;
      if (!active) begin
        cmd_ph <= 1'b1; rd_mode <= 1'b0; bit_cnt <= '0; sdo_oe_o <= 1'b0;
      end else if (rise) begin
        rx_sr   <= byte_full[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (cmd_ph) begin
            cmd_ph  <= 1'b0;
            rd_mode <= byte_full[7];
            addr_q  <= byte_full[6:0];
          end else begin
            addr_q <= addr_q + 7'd1;
            if (!rd_mode) begin
              wr_stb_o <= 1'b1;
              wr_o     <= '{addr: addr_q, data: byte_full};
            end
          end
          if (cmd_ph ? byte_full[7] : rd_mode) begin
            tx_sr  <= rdata_i;
            tx_hit <= rhit_i;
          end
        end
      end else if (fall && rd_mode && !cmd_ph) begin
        sdo_o    <= tx_sr[7];
        tx_sr    <= {tx_sr[6:0], 1'b0};
        sdo_oe_o <= tx_hit;
      end
    end
  end
endmodule

// File: rtl/hrp_regs.sv
module hrp_regs
  import hrp_pkg::*;
#(
  parameter int NUM_BS   = 14,
  parameter int NUM_CTRL = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sub_role_i,
  input  logic                  decoding_i,
  input  logic [NUM_BS*8-1:0]   bs_info_i,
  input  logic                  stat_we_i,
  input  logic [7:0]            stat_i,
  input  logic [7:0]            crc_i,
  input  logic [15:0]           wr_ptr_i,
  input  logic                  wr_stb_i,
  input  hrp_wr_t               wr_i,
  input  logic [6:0]            rd_addr_i,
  output logic [7:0]            rdata_o,
  output logic                  rhit_o,
  output logic [15:0]           rd_ptr_o,
  output logic [NUM_CTRL*8-1:0] ctrl_o
);
  localparam int CTRL_END = int'(OFF_CTRL) + NUM_CTRL;

  logic [7:0] stat_q, crc_q;
  logic       wr_hit;
  logic [5:0] woff, roff;

  assign woff   = wr_i.addr[5:0];
  assign roff   = rd_addr_i[5:0];
  assign wr_hit = wr_stb_i && (wr_i.addr[6] == sub_role_i);
  assign rhit_o = rd_addr_i[6] == sub_role_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= STAT_RST; crc_q <= '0;
    end else if (stat_we_i) begin
      stat_q <= stat_i; crc_q <= crc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_ptr_o <= '0;
    else if (wr_hit && !decoding_i) begin
      if (woff == OFF_RDP_H) rd_ptr_o[15:8] <= wr_i.data;
      if (woff == OFF_RDP_L) rd_ptr_o[7:0]  <= wr_i.data;
    end
  end

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
    localparam logic [5:0] OFF_K = 6'(int'(OFF_CTRL) + k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_o[k*8 +: 8] <= '0;
      else if (wr_hit && woff == OFF_K) ctrl_o[k*8 +: 8] <= wr_i.data;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(roff) < NUM_BS) rdata_o = bs_info_i[int'(roff)*8 +: 8];
    else if (roff == OFF_STAT)  rdata_o = stat_q;
    else if (roff == OFF_CRC)   rdata_o = crc_q;
    else if (roff == OFF_RDP_H) rdata_o = rd_ptr_o[15:8];
    else if (roff == OFF_RDP_L) rdata_o = rd_ptr_o[7:0];
    else if (roff == OFF_WRP_H) rdata_o = wr_ptr_i[15:8];
    else if (roff == OFF_WRP_L) rdata_o = wr_ptr_i[7:0];
    else if (roff >= OFF_CTRL && int'(roff) < CTRL_END)
      rdata_o = ctrl_o[(int'(roff) - int'(OFF_CTRL))*8 +: 8];
  end
endmodule

// File: rtl/hrp_host_port.sv
module hrp_host_port
  import hrp_pkg::*;
#(
  parameter int NUM_BS   = 14,
  parameter int NUM_CTRL = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sck_i,
  input  logic                  sdi_i,
  input  logic                  ss_ni,
  output logic                  sdo_o,
  output logic                  sdo_oe_o,
  input  logic                  sub_role_i,
  input  logic                  decoding_i,
  input  logic [NUM_BS*8-1:0]   bs_info_i,
  input  logic                  stat_we_i,
  input  logic [7:0]            stat_i,
  input  logic [7:0]            crc_i,
  input  logic [15:0]           wr_ptr_i,
  output logic [15:0]           rd_ptr_o,
  output logic [NUM_CTRL*8-1:0] ctrl_o
);
  logic       wr_stb, rhit;
  hrp_wr_t    wr_req;
  logic [6:0] look_addr, wr_addr;
  logic [7:0] rdata;

  assign wr_addr = wr_req.addr;

  hrp_serial_if u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .sdi_i(sdi_i), .ss_ni(ss_ni),
    .rdata_i(rdata), .rhit_i(rhit), .look_addr_o(look_addr),
    .wr_stb_o(wr_stb), .wr_o(wr_req), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  hrp_regs #(.NUM_BS(NUM_BS), .NUM_CTRL(NUM_CTRL)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .sub_role_i(sub_role_i), .decoding_i(decoding_i),
    .bs_info_i(bs_info_i), .stat_we_i(stat_we_i), .stat_i(stat_i), .crc_i(crc_i),
    .wr_ptr_i(wr_ptr_i), .wr_stb_i(wr_stb), .wr_i(wr_req), .rd_addr_i(look_addr),
    .rdata_o(rdata), .rhit_o(rhit), .rd_ptr_o(rd_ptr_o), .ctrl_o(ctrl_o)
  );
endmodule

// File: rtl/hrp_host_port_chk.sv
module hrp_host_port_chk #(
  parameter int NUM_CTRL = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ss_ni,
  input logic                  sdo_oe_o,
  input logic                  decoding_i,
  input logic                  sub_role_i,
  input logic [15:0]           rd_ptr_o,
  input logic [NUM_CTRL*8-1:0] ctrl_o,
  input logic                  wr_stb,
  input logic [6:0]            wr_addr
);
  // R2: output enable is gone once select has been high for a few cycles
  a_r2_oe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_ni && $past(ss_ni) && $past(ss_ni, 2) && $past(ss_ni, 3) |-> !sdo_oe_o);
  // R7: read pointer frozen while decoding
  a_r7_rdptr_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(decoding_i) |-> $stable(rd_ptr_o));
  // R9: control bytes change only after a write strobe
  a_r9_ctrl_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_stb) |-> $stable(ctrl_o));
  // R4: out-of-window writes touch nothing
  a_r4_window_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_stb) && ($past(wr_addr[6]) != $past(sub_role_i))
      |-> $stable(ctrl_o) && $stable(rd_ptr_o));
  // R1: one strobe per received data byte
  a_r1_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |=> !wr_stb);
endmodule

bind hrp_host_port hrp_host_port_chk #(.NUM_CTRL(NUM_CTRL)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ss_ni(ss_ni), .sdo_oe_o(sdo_oe_o),
  .decoding_i(decoding_i), .sub_role_i(sub_role_i), .rd_ptr_o(rd_ptr_o),
  .ctrl_o(ctrl_o), .wr_stb(wr_stb), .wr_addr(wr_addr)
);

// File: tb/hrp_host_port_tb_top.sv
module hrp_host_port_tb_top;
  localparam int NUM_BS = 14;
  localparam int NUM_CTRL = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, ss_n = 1'b1;
  logic sdo, sdo_oe;
  logic sub_role = 1'b0, decoding = 1'b0;
  logic [NUM_BS*8-1:0] bs_info;
  logic stat_we = 1'b0;
  logic [7:0] stat_v = '0, crc_v = '0;
  logic [15:0] wr_ptr = 16'hBEEF;
  logic [15:0] rd_ptr;
  logic [NUM_CTRL*8-1:0] ctrl;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  for (genvar n = 0; n < NUM_BS; n++) begin : g_bs
    assign bs_info[n*8 +: 8] = 8'hA0 + 8'(n);
  end

  hrp_host_port #(.NUM_BS(NUM_BS), .NUM_CTRL(NUM_CTRL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdi_i(sdi), .ss_ni(ss_n),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sub_role_i(sub_role), .decoding_i(decoding),
    .bs_info_i(bs_info), .stat_we_i(stat_we), .stat_i(stat_v), .crc_i(crc_v),
    .wr_ptr_i(wr_ptr), .rd_ptr_o(rd_ptr), .ctrl_o(ctrl)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, inout bit oe_any);
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i];
      wait_clk(HALF);
      rx[i] = sdo;
      oe_any |= sdo_oe;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  // two-byte capable transfer; n data bytes (1 or 2)
  task automatic xfer(input bit rd, input logic [6:0] a, input int n,
                      input logic [7:0] w0, input logic [7:0] w1,
                      output logic [7:0] r0, output logic [7:0] r1, output bit oe);
    logic [7:0] dummy;
    bit oe_cmd = 0;
    oe = 0; r1 = '0;
    ss_n = 1'b0;
    wait_clk(HALF);
    spi_byte({rd, a}, dummy, oe_cmd);
    spi_byte(w0, r0, oe);
    if (n > 1) spi_byte(w1, r1, oe);
    wait_clk(HALF);
    ss_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r0, r1; bit oe;
    xfer(1'b0, a, 1, d, 8'h00, r0, r1, oe);
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] d, output bit oe);
    logic [7:0] r1;
    xfer(1'b1, a, 1, 8'h00, 8'h00, d, r1, oe);
  endtask

  // {is_read, addr, wdata, exp_data, exp_oe}
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 7'h00, 8'h00, 8'hA0, 1'b1},  // R5
    {1'b1, 7'h0D, 8'h00, 8'hAD, 1'b1},  // R5
    {1'b0, 7'h05, 8'h55, 8'h00, 1'b0},
    {1'b1, 7'h05, 8'h00, 8'hA5, 1'b1},  // R5 ignored
    {1'b1, 7'h12, 8'h00, 8'hBE, 1'b1},  // R5
    {1'b0, 7'h13, 8'h11, 8'h00, 1'b0},
    {1'b1, 7'h13, 8'h00, 8'hEF, 1'b1},  // R5 ignored
    {1'b0, 7'h14, 8'h3C, 8'h00, 1'b0},
    {1'b1, 7'h14, 8'h00, 8'h3C, 1'b1},  // R9
    {1'b0, 7'h1B, 8'hC3, 8'h00, 1'b0},
    {1'b1, 7'h1B, 8'h00, 8'hC3, 1'b1},  // R9
    {1'b1, 7'h40, 8'h00, 8'h00, 1'b0},  // R4
    {1'b0, 7'h54, 8'hFF, 8'h00, 1'b0},
    {1'b1, 7'h14, 8'h00, 8'h3C, 1'b1},  // R4 ignored
    {1'b0, 7'h10, 8'h12, 8'h00, 1'b0},
    {1'b1, 7'h10, 8'h00, 8'h12, 1'b1}   // R7
  };

  initial begin
    logic [7:0] r0, r1; bit oe;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R6: reset state
    chk("R6 ctrl", ctrl[15:0], 16'h0);
    chk("R6 rdptr", rd_ptr, 16'h0);
    rd1(7'h0E, r0, oe); chk("R6 status", {8'h0, r0}, 16'h0003);
    rd1(7'h0F, r0, oe); chk("R6 crc", {8'h0, r0}, 16'h0000);
    chk("R2 oe in window", {15'h0, oe}, 16'h1);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][24]) begin
        rd1(VEC[v][23:17], r0, oe);
        chk($sformatf("R1 vec%0d oe", v), {15'h0, oe}, {15'h0, VEC[v][0]});
        if (VEC[v][0]) chk($sformatf("R2 vec%0d data", v), {8'h0, r0}, {8'h0, VEC[v][8:1]});
      end else begin
        wr1(VEC[v][23:17], VEC[v][16:9]);
      end
    end
    chk("R9 ctrl_o byte0", {8'h0, ctrl[7:0]}, 16'h003C);
    chk("R9 ctrl_o byte7", {8'h0, ctrl[63:56]}, 16'h00C3);

    // R8: two-byte write then two-byte read of the pointer
    xfer(1'b0, 7'h10, 2, 8'hAB, 8'hCD, r0, r1, oe);
    chk("R8 rd_ptr_o", rd_ptr, 16'hABCD);
    xfer(1'b1, 7'h12, 2, 8'h00, 8'h00, r0, r1, oe);
    chk("R8 burst read", {r0, r1}, 16'hBEEF);

    // R7: locked while decoding
    decoding = 1'b1;
    wr1(7'h11, 8'h77);
    chk("R7 locked port", rd_ptr, 16'hABCD);
    rd1(7'h11, r0, oe); chk("R7 locked read", {8'h0, r0}, 16'h00CD);
    decoding = 1'b0;

    // R10: status load
    @(negedge clk); stat_v = 8'h0C; crc_v = 8'h05; stat_we = 1'b1;
    @(negedge clk); stat_we = 1'b0;
    xfer(1'b1, 7'h0E, 2, 8'h00, 8'h00, r0, r1, oe);
    chk("R10 status/crc", {r0, r1}, 16'h0C05);

    // R3: sub role
    sub_role = 1'b1;
    rd1(7'h14, r0, oe); chk("R3 main addr silent", {15'h0, oe}, 16'h0);
    rd1(7'h54, r0, oe); chk("R3 sub read", {8'h0, r0}, 16'h003C);
    chk("R3 sub oe", {15'h0, oe}, 16'h1);
    wr1(7'h55, 8'h5A);
    chk("R3 sub write", {8'h0, ctrl[15:8]}, 16'h005A);
    wr1(7'h15, 8'hEE);
    chk("R4 main write ignored in sub", {8'h0, ctrl[15:8]}, 16'h005A);
    rd1(7'h52, r0, oe); chk("R3 sub wrptr", {8'h0, r0}, 16'h00BE);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule